// File: doc/BRIEF.md
# Boot Vector Loader

This block brings a small 32-bit core out of reset. Once reset is released it issues two word reads on a plain valid/ready read port and sets up the core from the results. The first read, at the vector base, gives the initial main stack pointer. The second read, one word higher, gives the entry address of the reset routine.

The loader splits bit 0 off the entry word and keeps it as the instruction-set state flag. It passes the remaining bits on as the program counter, with bit 0 at zero. The core supports only the compact instruction set, so this flag has to be 1. If the flag is 1, the loader raises a start signal that holds until the next reset. If the flag is 0, the loader raises a fault that holds until the next reset and never raises the start signal.

A read advances only on a cycle where valid and ready are both high. The address stays fixed while the request waits for ready.

Top module: `boot_vec_seq`

## Requirements
- R1: While reset is asserted, `pc_out`, `sp_out` and `tbit_out` are zero, and `mem_valid`, `core_go` and `vec_fault` are low.
- R2: The first accepted read is at byte address 0x00000000. `sp_out` takes that word with bits [1:0] cleared.
- R3: The second accepted read is at byte address 0x00000004. `pc_out` takes that word with bit 0 cleared.
- R4: `tbit_out` equals bit 0 of the second word, taken on the cycle that word is accepted.
- R5: When bit 0 of the second word is 1, `core_go` rises on the next cycle and stays high until reset, and `vec_fault` stays low.
- R6: When bit 0 of the second word is 0, `vec_fault` rises on the next cycle and stays high until reset, and `core_go` stays low.
- R7: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high and `mem_addr` unchanged.
- R8: Exactly two reads are accepted per reset. `mem_valid` is low once `core_go` or `vec_fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | AW | Byte address of the current read |
| mem_valid | output | 1 | Read request pending |
| mem_ready | input | 1 | Memory accepts the read this cycle |
| mem_rdata | input | 32 | Word returned, valid while mem_ready is high |
| sp_out | output | 32 | Main stack pointer, word aligned |
| pc_out | output | 32 | Program counter, bit 0 cleared |
| tbit_out | output | 1 | Instruction-set state flag |
| core_go | output | 1 | Core may begin fetching |
| vec_fault | output | 1 | Entry word had state flag 0 (sticky) |

## Verification
The bench builds the loader with its default parameters: a 32-bit address, the vectors at base zero and a 4-byte word step. These are the real boot addresses, so the address checks compare against 0x0 and 0x4 directly.

Random gaps in `mem_ready` bring the address-hold rule and the two-read ordering within reach. Random vector words, including all-ones, all-zeros and entry words with bit 0 clear, exercise both alignment masks and both the start and fault outcomes.

// File: rtl/bvs_pkg.sv
package bvs_pkg;

  localparam int unsigned CORE_W = 32;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_SP   = 3'd1,
    ST_PC   = 3'd2,
    ST_RUN  = 3'd3,
    ST_TRAP = 3'd4
  } bvs_state_e;

  // stack pointer is kept word aligned
  function automatic logic [CORE_W-1:0] sp_word_align(input logic [CORE_W-1:0] w);
    return {w[CORE_W-1:2], 2'b00};
  endfunction

  // entry address without the state flag
  function automatic logic [CORE_W-1:0] pc_strip_flag(input logic [CORE_W-1:0] w);
    return {w[CORE_W-1:1], 1'b0};
  endfunction

  function automatic logic flag_of(input logic [CORE_W-1:0] w);
    return w[0];
  endfunction

endpackage

// File: rtl/bvs_fsm.sv
module bvs_fsm
  import bvs_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned VEC_BASE   = 0,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_ready,
  input  logic          entry_flag,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic          hs_sp,
  output logic          hs_pc,
  output logic          core_go,
  output logic          vec_fault
);

  localparam logic [AW-1:0] SP_ADDR = AW'(VEC_BASE);
  localparam logic [AW-1:0] PC_ADDR = AW'(VEC_BASE + WORD_BYTES);

  bvs_state_e state_q, state_d;

  always_comb begin
    mem_valid = (state_q == ST_SP) || (state_q == ST_PC);
    mem_addr  = (state_q == ST_PC) ? PC_ADDR : SP_ADDR;
    hs_sp     = (state_q == ST_SP) && mem_ready;
    hs_pc     = (state_q == ST_PC) && mem_ready;
    core_go   = (state_q == ST_RUN);
    vec_fault = (state_q == ST_TRAP);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: state_d = ST_SP;
      ST_SP:   if (hs_sp) state_d = ST_PC;
      ST_PC:   if (hs_pc) state_d = entry_flag ? ST_RUN : ST_TRAP;
      ST_RUN:  state_d = ST_RUN;
      ST_TRAP: state_d = ST_TRAP;
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/bvs_regs.sv
module bvs_regs
  import bvs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_sp,
  input  logic              hs_pc,
  input  logic [CORE_W-1:0] rdata,
  output logic [CORE_W-1:0] sp_q,
  output logic [CORE_W-1:0] pc_q,
  output logic              tbit_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      pc_q   <= '0;
      tbit_q <= 1'b0;
    end else begin
      if (hs_sp) sp_q <= sp_word_align(rdata);
      if (hs_pc) begin
        pc_q   <= pc_strip_flag(rdata);
        tbit_q <= flag_of(rdata);
      end
    end
  end

endmodule

// File: rtl/boot_vec_seq.sv
module boot_vec_seq
  import bvs_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned VEC_BASE   = 0,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  input  logic [CORE_W-1:0] mem_rdata,
  output logic [CORE_W-1:0] sp_out,
  output logic [CORE_W-1:0] pc_out,
  output logic              tbit_out,
  output logic              core_go,
  output logic              vec_fault
);

  logic hs_sp;
  logic hs_pc;

  bvs_fsm #(
    .AW(AW), .VEC_BASE(VEC_BASE), .WORD_BYTES(WORD_BYTES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ready  (mem_ready),
    .entry_flag (flag_of(mem_rdata)),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .hs_sp      (hs_sp),
    .hs_pc      (hs_pc),
    .core_go    (core_go),
    .vec_fault  (vec_fault)
  );

  bvs_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_sp  (hs_sp),
    .hs_pc  (hs_pc),
    .rdata  (mem_rdata),
    .sp_q   (sp_out),
    .pc_q   (pc_out),
    .tbit_q (tbit_out)
  );

endmodule

// File: rtl/boot_vec_seq_chk.sv
module boot_vec_seq_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned VEC_BASE   = 0,
  parameter int unsigned WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [31:0]   mem_rdata,
  input logic [31:0]   sp_out,
  input logic [31:0]   pc_out,
  input logic          tbit_out,
  input logic          core_go,
  input logic          vec_fault,
  input logic          hs_sp,
  input logic          hs_pc
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (sp_out == '0 && pc_out == '0 && !tbit_out &&
                               !mem_valid && !core_go && !vec_fault);
    end
  end

  // R2
  sp_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_sp |-> mem_addr == AW'(VEC_BASE));

  // R2
  sp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_sp |=> sp_out == {$past(mem_rdata[31:2]), 2'b00});

  // R3
  pc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_pc |-> mem_addr == AW'(VEC_BASE + WORD_BYTES));

  // R4
  tbit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_pc |=> tbit_out == $past(mem_rdata[0]));

  // R5
  go_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_go |=> core_go && !vec_fault);

  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fault |=> vec_fault && !core_go);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr));

  // R8
  idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_go || vec_fault) |-> !mem_valid);

endmodule

bind boot_vec_seq boot_vec_seq_chk #(
  .AW(AW), .VEC_BASE(VEC_BASE), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_rdata(mem_rdata), .sp_out(sp_out),
  .pc_out(pc_out), .tbit_out(tbit_out), .core_go(core_go),
  .vec_fault(vec_fault), .hs_sp(hs_sp), .hs_pc(hs_pc)
);

// File: tb/boot_vec_seq_test.sv
`timescale 1ns/1ps
module boot_vec_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata;
  logic [31:0] sp_out, pc_out;
  logic        tbit_out, core_go, vec_fault;

  logic [31:0] w_sp, w_pc;
  int          n_checks = 0;
  int          n_fail   = 0;
  int          cycles   = 0;

  always #4 clk = ~clk;

  assign mem_rdata = (mem_addr == 32'h0) ? w_sp :
                     (mem_addr == 32'h4) ? w_pc : 32'hBAD0_BAD0;

  boot_vec_seq uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .sp_out(sp_out),
    .pc_out(pc_out), .tbit_out(tbit_out), .core_go(core_go),
    .vec_fault(vec_fault)
  );

  function automatic logic [31:0] want_sp(input logic [31:0] w);
    return w & 32'hFFFF_FFFC;
  endfunction

  function automatic logic [31:0] want_pc(input logic [31:0] w);
    return w & 32'hFFFF_FFFE;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", cycles, 150000);
      finish_run();
    end
  end

  // one boot; ready_pct is the chance of ready on each cycle
  task automatic boot(input logic [31:0] s, input logic [31:0] p, input int ready_pct);
    int          hs_n = 0;
    int          ord_err = 0;
    int          stab_err = 0;
    bit          pend = 0;
    logic [31:0] pend_addr = '0;
    bit          r;
    w_sp = s;
    w_pc = p;
    @(negedge clk);
    rst_n = 1'b0;
    mem_ready = 1'b0;
    repeat (2) @(negedge clk);
    // R1
    check(sp_out == 0 && pc_out == 0 && !tbit_out && !mem_valid && !core_go && !vec_fault,
          "R1 reset state", {sp_out[15:0], pc_out[11:0], tbit_out, mem_valid, core_go, vec_fault},
          32'h0);
    rst_n = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (pend && !(mem_valid && mem_addr == pend_addr)) stab_err++;
      r = (($urandom % 100) < ready_pct);
      mem_ready = r;
      if (mem_valid && r) begin
        if (hs_n == 0 && mem_addr != 32'h0) ord_err++;
        if (hs_n == 1 && mem_addr != 32'h4) ord_err++;
        hs_n++;
      end
      pend = mem_valid && !r;
      pend_addr = mem_addr;
    end
    @(negedge clk);
    // R8
    check(hs_n == 2, "R8 read count", 32'(hs_n), 32'd2);
    check(!mem_valid, "R8 valid low at end", {31'b0, mem_valid}, 32'h0);
    // R2 R3
    check(ord_err == 0, "R2/R3 read order", 32'(ord_err), 32'h0);
    // R2
    check(sp_out == want_sp(s), "R2 stack pointer", sp_out, want_sp(s));
    // R3
    check(pc_out == want_pc(p), "R3 program counter", pc_out, want_pc(p));
    // R4
    check(tbit_out == p[0], "R4 state flag", {31'b0, tbit_out}, {31'b0, p[0]});
    // R5
    check(core_go == p[0], "R5 start output", {31'b0, core_go}, {31'b0, p[0]});
    // R6
    check(vec_fault == !p[0], "R6 fault output", {31'b0, vec_fault}, {31'b0, !p[0]});
    // R7
    check(stab_err == 0, "R7 address hold", 32'(stab_err), 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    boot(32'h2000_1000, 32'h0000_0101, 100);
    boot(32'h2000_1000, 32'h0000_0100, 100);
    boot(32'hFFFF_FFFF, 32'hFFFF_FFFF, 30);
    boot(32'h0000_0003, 32'h0000_0000, 30);
    boot(32'h2000_0402, 32'h0800_01C5, 5);
    for (int k = 0; k < 30; k++) boot($urandom, $urandom, 50);
    finish_run();
  end

endmodule